// File: doc/BRIEF.md
# Floating-Diffusion Reset and Correlated Double Sampling Strobe Generator

This block produces the per-pixel waveforms that read a serial charge-transfer image sensor: two complementary horizontal transfer phases, a pulse that resets the output floating diffusion, and the two one-tick strobes that drive an external correlated double sampler. The strobe that captures the reference level is called clamp. The strobe that captures the signal level is called sample. The block runs from an oversampling clock at a fixed multiple of the pixel rate. The default is eight ticks per pixel, which gives about 70 ns per pixel at the usual horizontal rate. Every pulse edge therefore falls on a tick boundary.

The line timing generator supplies a pixel-enable window. While the window is open, the block repeats pixels back to back. When the window closes, every output is held low.

Three programmable tick counts set the waveform: the reset width, the clamp position and the sample position. The reset pulse starts on the same tick as the rising edge of the second phase. Charge reaches the floating diffusion on the falling edge of that phase. The clamp and sample strobes follow inside the same pixel. Before use, the block forces the settings into a legal order:
- the reset ends within the second phase's high time;
- the clamp comes no earlier than the end of the reset;
- the sample comes after the clamp.

The settings are captured once per pixel, so a write in the middle of a pixel never distorts that pixel.

Top module: `ccd_cds_pulse_gen`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, h1_o, h2_o, fd_rst_o, clamp_o and sample_o are all 0, whatever pix_en_i is.
- R2: Starting with the first clock edge after pix_en_i is sampled low, all five outputs are 0, and they stay 0 while pix_en_i stays low.
- R3: When pix_en_i is sampled high after being low, the outputs stay 0 after that edge. Pixel phase 0 appears after the next edge. Phases then advance by one per clock and wrap from N-1 (N = TICKS_PER_PIX, default 8) back to 0 with no gap.
- R4: While a pixel runs, h2_o is 1 on phases 0 to H2_HIGH_TICKS-1 (default 4) and 0 on the rest of the pixel. h1_o is always the inverse of h2_o.
- R5: fd_rst_o is 1 on phases 0 to Wr-1, where Wr is the effective reset width. It therefore rises on the same tick as h2_o and lies entirely within the high time of h2_o.
- R6: clamp_o is high for exactly one tick per pixel, on phase Cc, the effective clamp position. That tick is never one on which fd_rst_o is high.
- R7: sample_o is high for exactly one tick per pixel, on phase Ss, the effective sample position. Ss is always later than the clamp in the same pixel.
- R8: The effective values are derived from the settings (phase positions count from 0):
  - Wr: rst_width_i limited to the range 1 to H2_HIGH_TICKS.
  - Cc: clamp_dly_i limited to the range Wr to N-2.
  - Ss: sample_dly_i if it lies between Cc+1 and N-1. A setting of Cc or below gives Cc+1. A setting above N-1 gives N-1.
- R9: The settings are captured on the clock edge that starts a pixel, which is the edge after which the phase counter is 0. A change made in the middle of a pixel first appears in the next pixel.
- R10: If the window closes in the middle of a pixel and later opens again, the new run begins at phase 0, with the latency of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, TICKS_PER_PIX ticks per pixel |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_en_i | input | 1 | Pixel-enable window from the line timing generator |
| rst_width_i | input | CW | Requested reset pulse width in ticks |
| clamp_dly_i | input | CW | Requested clamp strobe phase in ticks from pixel start |
| sample_dly_i | input | CW | Requested sample strobe phase in ticks from pixel start |
| h1_o | output | 1 | Horizontal transfer phase 1 |
| h2_o | output | 1 | Horizontal transfer phase 2 |
| fd_rst_o | output | 1 | Floating-diffusion reset pulse |
| clamp_o | output | 1 | Reference-level strobe for the sampler |
| sample_o | output | 1 | Signal-level strobe for the sampler |

## Verification
Every output is registered, and the phase counter sits one register ahead of the outputs. Once the window opens, pixel phase 0 therefore becomes visible after the second clock edge. Closing the window clears the outputs after the first edge, because the decode is gated directly by pix_en_i. A setting change first shows up on the outputs one edge after the pixel-start edge that captures it.

The bench changes inputs only on falling edges and reads the outputs on the following falling edges. Each check is placed at the falling edge that matches this count: the edge right after the window opens must still read idle, and the phase count starts at the falling edge after that.

// File: rtl/ccd_cds_pkg.sv
package ccd_cds_pkg;

  // Bundle of the per-tick output levels.
  typedef struct packed {
    logic h1;
    logic h2;
    logic fd_rst;
    logic clamp;
    logic sample;
  } cds_wave_t;

  // Reset width: at least one tick, at most the H2 high time.
  function automatic int sat_rst_width(input int req, input int h2_high);
    if (req < 1)       return 1;
    if (req > h2_high) return h2_high;
    return req;
  endfunction

  // Clamp phase: not before the reset ends, and room left for the sample.
  function automatic int sat_clamp_pos(input int req, input int width, input int ticks);
    if (req < width)     return width;
    if (req > ticks - 2) return ticks - 2;
    return req;
  endfunction

  // Sample phase: strictly after the clamp, inside the pixel.
  function automatic int sat_sample_pos(input int req, input int clamp, input int ticks);
    if (req <= clamp)    return clamp + 1;
    if (req > ticks - 1) return ticks - 1;
    return req;
  endfunction

endpackage

// File: rtl/cds_phase_counter.sv
module cds_phase_counter #(
  parameter int TICKS_PER_PIX = 8,
  localparam int CW = $clog2(TICKS_PER_PIX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  output logic          active_o,
  output logic [CW-1:0] phase_o,
  output logic          pix_start_o
);

  localparam logic [CW-1:0] LAST_PH = CW'(TICKS_PER_PIX - 1);

  logic at_last;

  assign at_last     = (phase_o == LAST_PH);
  // The coming edge loads phase 0 (first pixel or a wrap).
  assign pix_start_o = pix_en_i && (!active_o || at_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      phase_o  <= '0;
    end else if (!pix_en_i) begin
      active_o <= 1'b0;
      phase_o  <= '0;
    end else if (pix_start_o) begin
      active_o <= 1'b1;
      phase_o  <= '0;
    end else begin
      phase_o  <= phase_o + 1'b1;
    end
  end

endmodule

// File: rtl/cds_cfg_latch.sv
module cds_cfg_latch
  import ccd_cds_pkg::*;
#(
  parameter int TICKS_PER_PIX = 8,
  parameter int H2_HIGH_TICKS = TICKS_PER_PIX / 2,
  localparam int CW = $clog2(TICKS_PER_PIX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] rst_width_i,
  input  logic [CW-1:0] clamp_dly_i,
  input  logic [CW-1:0] sample_dly_i,
  output logic [CW-1:0] eff_rst_o,
  output logic [CW-1:0] eff_clamp_o,
  output logic [CW-1:0] eff_sample_o
);

  // Legal values for an all-zero request, used as the reset state.
  localparam int RST_W0 = sat_rst_width(0, H2_HIGH_TICKS);
  localparam int RST_C0 = sat_clamp_pos(0, RST_W0, TICKS_PER_PIX);
  localparam int RST_S0 = sat_sample_pos(0, RST_C0, TICKS_PER_PIX);

  int w_sat, c_sat, s_sat;

  always_comb begin
    w_sat = sat_rst_width(int'(rst_width_i), H2_HIGH_TICKS);
    c_sat = sat_clamp_pos(int'(clamp_dly_i), w_sat, TICKS_PER_PIX);
    s_sat = sat_sample_pos(int'(sample_dly_i), c_sat, TICKS_PER_PIX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_rst_o    <= CW'(RST_W0);
      eff_clamp_o  <= CW'(RST_C0);
      eff_sample_o <= CW'(RST_S0);
    end else if (load_i) begin
      eff_rst_o    <= CW'(w_sat);
      eff_clamp_o  <= CW'(c_sat);
      eff_sample_o <= CW'(s_sat);
    end
  end

endmodule

// File: rtl/cds_strobe_decode.sv
module cds_strobe_decode
  import ccd_cds_pkg::*;
#(
  parameter int TICKS_PER_PIX = 8,
  parameter int H2_HIGH_TICKS = TICKS_PER_PIX / 2,
  localparam int CW = $clog2(TICKS_PER_PIX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] phase_i,
  input  logic [CW-1:0] eff_rst_i,
  input  logic [CW-1:0] eff_clamp_i,
  input  logic [CW-1:0] eff_sample_i,
  output cds_wave_t     wave_o
);

  localparam logic [CW-1:0] H2_HI = CW'(H2_HIGH_TICKS);

  // Named per-tick events.
  logic in_h2_high, in_reset, at_clamp, at_sample;
  cds_wave_t wave_d;

  assign in_h2_high = (phase_i < H2_HI);
  assign in_reset   = (phase_i < eff_rst_i);
  assign at_clamp   = (phase_i == eff_clamp_i);
  assign at_sample  = (phase_i == eff_sample_i);

  always_comb begin
    wave_d = '0;
    if (run_i) begin
      wave_d.h2     = in_h2_high;
      wave_d.h1     = !in_h2_high;
      wave_d.fd_rst = in_reset;
      wave_d.clamp  = at_clamp;
      wave_d.sample = at_sample;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_o <= '0;
    else         wave_o <= wave_d;
  end

endmodule

// File: rtl/ccd_cds_pulse_gen.sv
module ccd_cds_pulse_gen
  import ccd_cds_pkg::*;
#(
  parameter int TICKS_PER_PIX = 8,
  parameter int H2_HIGH_TICKS = TICKS_PER_PIX / 2,
  localparam int CW = $clog2(TICKS_PER_PIX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic [CW-1:0] rst_width_i,
  input  logic [CW-1:0] clamp_dly_i,
  input  logic [CW-1:0] sample_dly_i,
  output logic          h1_o,
  output logic          h2_o,
  output logic          fd_rst_o,
  output logic          clamp_o,
  output logic          sample_o
);

  logic          active;
  logic          pix_start;
  logic          run;
  logic [CW-1:0] phase;
  logic [CW-1:0] eff_rst, eff_clamp, eff_sample;
  cds_wave_t     wave;

  cds_phase_counter #(.TICKS_PER_PIX(TICKS_PER_PIX)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_en_i   (pix_en_i),
    .active_o   (active),
    .phase_o    (phase),
    .pix_start_o(pix_start)
  );

  cds_cfg_latch #(
    .TICKS_PER_PIX(TICKS_PER_PIX),
    .H2_HIGH_TICKS(H2_HIGH_TICKS)
  ) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (pix_start),
    .rst_width_i (rst_width_i),
    .clamp_dly_i (clamp_dly_i),
    .sample_dly_i(sample_dly_i),
    .eff_rst_o   (eff_rst),
    .eff_clamp_o (eff_clamp),
    .eff_sample_o(eff_sample)
  );

  // The open window gates the decode directly, so a closing window
  // silences the outputs on the next edge.
  assign run = pix_en_i && active;

  cds_strobe_decode #(
    .TICKS_PER_PIX(TICKS_PER_PIX),
    .H2_HIGH_TICKS(H2_HIGH_TICKS)
  ) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .phase_i     (phase),
    .eff_rst_i   (eff_rst),
    .eff_clamp_i (eff_clamp),
    .eff_sample_i(eff_sample),
    .wave_o      (wave)
  );

  assign h1_o     = wave.h1;
  assign h2_o     = wave.h2;
  assign fd_rst_o = wave.fd_rst;
  assign clamp_o  = wave.clamp;
  assign sample_o = wave.sample;

endmodule

// File: rtl/ccd_cds_pulse_gen_chk.sv
module ccd_cds_pulse_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pix_en_i,
  input logic h1_o,
  input logic h2_o,
  input logic fd_rst_o,
  input logic clamp_o,
  input logic sample_o
);

  // Set when a clamp has occurred since the last reset pulse.
  logic clamp_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       clamp_seen <= 1'b0;
    else if (fd_rst_o) clamp_seen <= 1'b0;
    else if (clamp_o)  clamp_seen <= 1'b1;
  end

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pix_en_i) |-> !(h1_o || h2_o || fd_rst_o || clamp_o || sample_o));

  p_h_compl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h1_o || h2_o) |-> (h1_o != h2_o));

  p_rst_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fd_rst_o) |-> $rose(h2_o));

  p_rst_in_h2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fd_rst_o |-> h2_o);

  p_clamp_not_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> !fd_rst_o && !sample_o);

  p_sample_after_clamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> clamp_seen && !fd_rst_o);

endmodule

bind ccd_cds_pulse_gen ccd_cds_pulse_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pix_en_i(pix_en_i),
  .h1_o    (h1_o),
  .h2_o    (h2_o),
  .fd_rst_o(fd_rst_o),
  .clamp_o (clamp_o),
  .sample_o(sample_o)
);

// File: tb/ccd_cds_pulse_gen_tb.sv
`timescale 1ns/1ps
module ccd_cds_pulse_gen_tb;

  localparam int N    = 8;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_en;
  logic [2:0] rst_w, clamp_d, sample_d;
  logic       h1, h2, fd_rst, clamp, sample;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ccd_cds_pulse_gen u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pix_en_i    (pix_en),
    .rst_width_i (rst_w),
    .clamp_dly_i (clamp_d),
    .sample_dly_i(sample_d),
    .h1_o        (h1),
    .h2_o        (h2),
    .fd_rst_o    (fd_rst),
    .clamp_o     (clamp),
    .sample_o    (sample)
  );

  // Requested width/clamp/sample, then the effective values expected per R8.
  localparam int VEC [6][6] = '{
    '{2, 3, 6,  2, 3, 6},
    '{0, 1, 5,  1, 1, 5},
    '{6, 2, 3,  4, 4, 5},
    '{3, 7, 7,  3, 6, 7},
    '{1, 5, 2,  1, 5, 6},
    '{4, 4, 4,  4, 4, 5}
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    chk(req, "h1", int'(h1), 0);
    chk(req, "h2", int'(h2), 0);
    chk(req, "fd_rst", int'(fd_rst), 0);
    chk(req, "clamp", int'(clamp), 0);
    chk(req, "sample", int'(sample), 0);
  endtask

  task automatic check_tick(input string ctx, input int p, input int wr, input int cc, input int ss);
    bit h2_exp;
    h2_exp = (p < HALF);
    chk({"R4 ", ctx}, $sformatf("h2 ph%0d", p), int'(h2), int'(h2_exp));
    chk({"R4 ", ctx}, $sformatf("h1 ph%0d", p), int'(h1), int'(!h2_exp));
    chk({"R5 ", ctx}, $sformatf("fd_rst ph%0d", p), int'(fd_rst), int'(p < wr));
    chk({"R6 ", ctx}, $sformatf("clamp ph%0d", p), int'(clamp), int'(p == cc));
    chk({"R7 ", ctx}, $sformatf("sample ph%0d", p), int'(sample), int'(p == ss));
  endtask

  task automatic set_cfg(input int w, input int c, input int s);
    rst_w    = 3'(w);
    clamp_d  = 3'(c);
    sample_d = 3'(s);
  endtask

  // Called on a falling edge: opens the window; outputs stay idle one more edge (R3).
  task automatic open_window(input string req);
    pix_en = 1'b1;
    @(negedge clk);
    check_idle(req);
  endtask

  initial begin
    pix_en = 1'b1;
    rst_n  = 1'b0;
    set_cfg(2, 3, 6);
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    pix_en = 1'b0;
    rst_n  = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");

    // Table walk: two back-to-back pixels per setting (R3, R8).
    for (int v = 0; v < 6; v++) begin
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2]);
      repeat (2) @(negedge clk);
      check_idle("R2 window closed");
      open_window("R3 first edge");
      for (int t = 0; t < 2 * N; t++) begin
        @(negedge clk);
        check_tick($sformatf("R8 R3 vec%0d", v), t % N, VEC[v][3], VEC[v][4], VEC[v][5]);
      end
      pix_en = 1'b0;
      @(negedge clk);
      check_idle("R2 after close");
    end

    // R9: mid-pixel write lands in the following pixel.
    set_cfg(2, 3, 6);
    @(negedge clk);
    open_window("R3 before R9");
    for (int t = 0; t < 2 * N; t++) begin
      @(negedge clk);
      if (t < N) check_tick("R9 old", t % N, 2, 3, 6);
      else       check_tick("R9 new", t % N, 1, 5, 7);
      if (t == 3) set_cfg(1, 5, 7);
    end
    pix_en = 1'b0;
    @(negedge clk);
    check_idle("R2 after R9");

    // R10: close mid-pixel, reopen, restart at phase 0.
    set_cfg(3, 4, 6);
    @(negedge clk);
    open_window("R3 before R10");
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      check_tick("R10 partial", t, 3, 4, 6);
    end
    pix_en = 1'b0;
    @(negedge clk);
    check_idle("R2 mid-pixel close");
    repeat (3) begin
      @(negedge clk);
      check_idle("R2 held closed");
    end
    open_window("R10 reopen");
    for (int t = 0; t < N; t++) begin
      @(negedge clk);
      check_tick("R10 restart", t, 3, 4, 6);
    end
    pix_en = 1'b0;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule